// File: doc/BRIEF.md
# Flit-to-Packet Reassembler

This block sits on the receive side of one virtual network in a mesh tile. The router hands it flits one at a time, each marked by a valid strobe. There is no flit FIFO in front of the assembly logic. Every flit has a two-bit kind field, a virtual-channel tag and a fixed-width payload. The block collects the payloads of one packet into an assembly register. When the packet's last flit is accepted, it writes the finished packet into an output packet FIFO in that same cycle. The tile-side consumer reads the oldest packet from the FIFO and pulses a consumed strobe to remove it.

The packet width is the flit count times the payload width. The flit count is the packet body width divided by the payload width, rounded up. The earliest payload goes in the lowest slot of the packet. Slots that a short packet does not reach read as zero.

Toward the router the block raises an on-off almost-full signal. The router reacts to it one cycle late, so the threshold sits two entries below the FIFO depth. A run of back-to-back one-flit packets is then never lost. If the flit sequence is broken, the block raises a sticky error flag: a new packet can start before the previous one has ended, or a packet can carry more flits than fit. The flag stays set until reset.

Top module: `flit_reassembler`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block empties the packet FIFO, clears the assembly register and slot pointer, and clears the error flag. After reset, `pkt_valid`, `almost_full` and `proto_err` are all 0.
- R2: A flit is taken only at a clock edge where `flit_valid` is 1. The kind encodings are head 2'b00, body 2'b01, tail 2'b10 and single-flit 2'b11. The value of `flit_vcid` has no effect on the assembled packets.
- R3: The k-th accepted payload of a packet (k counted from 0) lands in `pkt_data[k*PAYLOAD_W +: PAYLOAD_W]`. With 8-bit payloads, the sequence head 0x20, body 0x40, body 0x60, tail 0x10 yields 32'h10604020.
- R4: A single-flit packet puts its payload in slot 0 with every other slot zero. A packet shorter than the flit count has zero in every slot it did not fill, whatever earlier packets held.
- R5: The rising edge that accepts a tail or single-flit flit writes the finished packet into the FIFO. If the FIFO was empty, `pkt_valid` is 1 and `pkt_data` shows that packet right after that edge. Packets leave the FIFO in arrival order.
- R6: A 1 on `pkt_consumed` at a rising edge removes the oldest packet. When the FIFO is empty, the pulse is ignored.
- R7: `almost_full` is 1 exactly when the FIFO holds at least FIFO_DEPTH-2 packets. A sender that sends one-flit packets every cycle and stops one cycle after it sees `almost_full` loses none of them.
- R8: A head or single-flit flit that arrives while a packet is partly assembled drops the partial packet, starts over from slot 0, and sets `proto_err`. `proto_err` stays 1 until reset.
- R9: A body or tail flit that arrives when all slots are already filled has its payload discarded and sets `proto_err`. A tail flit in that case still completes the packet with the slots already filled.
- R10: A packet completed while the FIFO is full and `pkt_consumed` is 0 is discarded, and the FIFO contents do not change. If `pkt_consumed` is 1 in the same cycle, the oldest packet leaves and the new one is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| flit_valid | input | 1 | Flit strobe from the router |
| flit_kind | input | 2 | Flit kind: head, body, tail, single |
| flit_vcid | input | VCID_W | Virtual-channel tag, not used for assembly |
| flit_payload | input | PAYLOAD_W | Flit payload |
| pkt_valid | output | 1 | Output FIFO holds at least one packet |
| pkt_data | output | PACKET_W | Oldest packet, zero when empty |
| pkt_consumed | input | 1 | Consumer removes the oldest packet |
| almost_full | output | 1 | On-off backpressure toward the router |
| proto_err | output | 1 | Sticky flag for a broken flit sequence |

## Verification
The two functions that can fall in the same cycle are completing a packet into the FIFO and the consumer's dequeue. The clearest case is when the FIFO is full. The bench first fills the FIFO and checks that a lone completion at full is dropped. It then drives a single-flit packet and a consume pulse on the same edge. Draining the FIFO afterwards must return the seven older packets in order, followed by the new one. The on-off threshold is judged by a sender whose stop reacts one cycle late. The bench checks the exact packet count at which `almost_full` rises and that every packet sent comes back out.

// File: rtl/reasm_pkg.sv
// Shared types for the flit reassembler.
// Assumes the router encodes the flit kind on two bits as listed below.
package reasm_pkg;

    typedef enum logic [1:0] {
        FLIT_HEAD = 2'b00,
        FLIT_BODY = 2'b01,
        FLIT_TAIL = 2'b10,
        FLIT_SOLO = 2'b11
    } flit_kind_t;

endpackage

// File: rtl/reasm_assembler.sv
// Packet assembly control. Gathers flit payloads into an assembly register,
// one slot per flit. The earliest payload goes in slot 0. The module flags a
// finished packet in the cycle its tail or single-flit flit is accepted.
// Assumes flits of one packet arrive unbroken, with no flit buffer in front.
// A broken sequence restarts or truncates the packet and sets a sticky error.
module reasm_assembler
    import reasm_pkg::*;
#(
    parameter int PAYLOAD_W = 8,
    parameter int FLITS     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flit_valid,
    input  flit_kind_t                    flit_kind,
    input  logic [PAYLOAD_W-1:0]          flit_payload,
    output logic                          done_valid,
    output logic [FLITS*PAYLOAD_W-1:0]    done_pkt,
    output logic                          proto_err
);

    localparam int PACKET_W = FLITS * PAYLOAD_W;
    localparam int SLOT_W   = $clog2(FLITS + 1);

    logic [SLOT_W-1:0]   slot_q;
    logic [PACKET_W-1:0] acc_q;
    logic                err_q;

    logic                is_head, is_body, is_tail, is_solo;
    logic                starts_pkt, ends_pkt, room;
    logic [PACKET_W-1:0] base;
    logic [SLOT_W-1:0]   wr_slot;
    logic                wr_ok;
    logic [PACKET_W-1:0] merged;
    logic                restart_err, overrun_err;

    // Decode the flit kind and find where the payload goes.
    always_comb begin
        is_head     = (flit_kind == FLIT_HEAD);
        is_body     = (flit_kind == FLIT_BODY);
        is_tail     = (flit_kind == FLIT_TAIL);
        is_solo     = (flit_kind == FLIT_SOLO);
        starts_pkt  = is_head | is_solo;
        ends_pkt    = is_tail | is_solo;
        room        = (slot_q < SLOT_W'(FLITS));
        base        = starts_pkt ? '0 : acc_q;
        wr_slot     = starts_pkt ? '0 : slot_q;
        wr_ok       = starts_pkt | room;
        restart_err = flit_valid & starts_pkt & (slot_q != '0);
        overrun_err = flit_valid & (is_body | is_tail) & ~room;
    end

    // Per-slot merge: the target slot takes the payload, the others keep the base.
    for (genvar s = 0; s < FLITS; s++) begin : g_slot
        assign merged[s*PAYLOAD_W +: PAYLOAD_W] =
            (wr_ok && (wr_slot == SLOT_W'(s))) ? flit_payload
                                                 : base[s*PAYLOAD_W +: PAYLOAD_W];
    end

    assign done_valid = flit_valid & ends_pkt;
    assign done_pkt   = merged;
    assign proto_err  = err_q;

    // Advance the slot pointer and keep the partial packet between flits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            acc_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            if (flit_valid) begin
                if (ends_pkt) begin
                    slot_q <= '0;
                    acc_q  <= '0;
                end else begin
                    acc_q <= merged;
                    if (is_head)
                        slot_q <= SLOT_W'(1);
                    else if (room)
                        slot_q <= slot_q + SLOT_W'(1);
                end
            end
            if (restart_err || overrun_err)
                err_q <= 1'b1;
        end
    end

    // R5: the pointer rewinds after a packet ends.
    a_r5_slot_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && ends_pkt) |=> (slot_q == '0));

    // R8: a head flit always leaves exactly one slot filled.
    a_r8_head_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && is_head) |=> (slot_q == SLOT_W'(1)));

    // R8: the error flag never clears on its own.
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R9: the pointer never passes the slot count.
    a_r9_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= SLOT_W'(FLITS));

    // R9: an extra body flit leaves the pointer parked and flags the error.
    a_r9_overrun_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && is_body && slot_q == SLOT_W'(FLITS))
            |=> (slot_q == SLOT_W'(FLITS) && err_q));

endmodule

// File: rtl/reasm_pkt_fifo.sv
// Output packet queue with an on-off almost-full level two below its depth.
// A push while full is dropped unless a pop happens in the same cycle.
// A pop while empty is ignored. Assumes DEPTH of at least 4.
module reasm_pkt_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_req,
    output logic             head_valid,
    output logic [WIDTH-1:0] head_data,
    output logic             almost_full
);

    localparam int IDX_W    = $clog2(DEPTH);
    localparam int CNT_W    = $clog2(DEPTH + 1);
    localparam int AF_LEVEL = DEPTH - 2;

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [IDX_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] count_q;
    logic             empty, full, do_push, do_pop;

    // Work out which side of the queue moves this cycle.
    always_comb begin
        empty   = (count_q == '0);
        full    = (count_q == CNT_W'(DEPTH));
        do_pop  = pop_req & ~empty;
        do_push = push_req & (~full | do_pop);
    end

    // Store the incoming packet in the slot the write pointer names.
    always_ff @(posedge clk) begin
        if (do_push)
            mem_q[wr_q] <= push_data;
    end

    // Move the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
        end else begin
            if (do_push)
                wr_q <= (wr_q == IDX_W'(DEPTH - 1)) ? '0 : wr_q + IDX_W'(1);
            if (do_pop)
                rd_q <= (rd_q == IDX_W'(DEPTH - 1)) ? '0 : rd_q + IDX_W'(1);
            if (do_push && !do_pop)
                count_q <= count_q + CNT_W'(1);
            else if (do_pop && !do_push)
                count_q <= count_q - CNT_W'(1);
        end
    end

    assign head_valid  = ~empty;
    assign head_data   = empty ? '0 : mem_q[rd_q];
    assign almost_full = (count_q >= CNT_W'(AF_LEVEL));

    // R7: occupancy never exceeds the depth.
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    // R6: a consume on an empty queue leaves it empty.
    a_r6_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop_req && !push_req) |=> (count_q == '0));

    // R6: a lone consume removes exactly one packet.
    a_r6_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && pop_req && !push_req) |=> (count_q == $past(count_q) - CNT_W'(1)));

    // R10: a completion at full with no consume changes nothing.
    a_r10_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && !pop_req) |=> (full && $stable(wr_q) && $stable(rd_q)));

    // R10: completion and consume together at full keep the queue full.
    a_r10_swap_at_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && pop_req) |=> full);

endmodule

// File: rtl/flit_reassembler.sv
// Receive side of one virtual network. Flits from the router feed the
// assembler directly. Finished packets go into the output queue, which the
// tile reads with a consume pulse. Assumes the router stops sending one
// cycle after it sees almost_full.
module flit_reassembler
    import reasm_pkg::*;
#(
    parameter  int PAYLOAD_W  = 8,
    parameter  int BODY_W     = 32,
    parameter  int VCID_W     = 2,
    parameter  int FIFO_DEPTH = 8,
    localparam int FLITS      = (BODY_W + PAYLOAD_W - 1) / PAYLOAD_W,
    localparam int PACKET_W   = FLITS * PAYLOAD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flit_valid,
    input  logic [1:0]           flit_kind,
    input  logic [VCID_W-1:0]    flit_vcid,
    input  logic [PAYLOAD_W-1:0] flit_payload,
    output logic                 pkt_valid,
    output logic [PACKET_W-1:0]  pkt_data,
    input  logic                 pkt_consumed,
    output logic                 almost_full,
    output logic                 proto_err
);

    logic                done_valid;
    logic [PACKET_W-1:0] done_pkt;

    reasm_assembler #(
        .PAYLOAD_W (PAYLOAD_W),
        .FLITS     (FLITS)
    ) u_asm (
        .clk          (clk),
        .rst_n        (rst_n),
        .flit_valid   (flit_valid),
        .flit_kind    (flit_kind_t'(flit_kind)),
        .flit_payload (flit_payload),
        .done_valid   (done_valid),
        .done_pkt     (done_pkt),
        .proto_err    (proto_err)
    );

    reasm_pkt_fifo #(
        .WIDTH (PACKET_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_req    (done_valid),
        .push_data   (done_pkt),
        .pop_req     (pkt_consumed),
        .head_valid  (pkt_valid),
        .head_data   (pkt_data),
        .almost_full (almost_full)
    );

    // R2: the tag carries no meaning here but must be driven with a flit.
    a_r2_vcid_known: assert property (@(posedge clk) disable iff (!rst_n)
        flit_valid |-> !$isunknown(flit_vcid));

    // R5: a completion into an empty queue shows up as a valid packet next.
    a_r5_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !pkt_valid) |=> pkt_valid);

endmodule

// File: tb/test_flit_reassembler.sv
module test_flit_reassembler;

    localparam int CLK_PERIOD = 10;
    localparam int PW         = 8;
    localparam int PKW        = 32;
    localparam logic [1:0] K_HEAD = 2'b00;
    localparam logic [1:0] K_BODY = 2'b01;
    localparam logic [1:0] K_TAIL = 2'b10;
    localparam logic [1:0] K_SOLO = 2'b11;

    // Vector: {flit count[3], kinds[8] (flit 0 lowest), payloads[32], expected[32]}
    localparam logic [74:0] VEC [5] = '{
        {3'd4, 8'h94, 32'h10604020, 32'h10604020},
        {3'd1, 8'h03, 32'h0000005A, 32'h0000005A},
        {3'd3, 8'h24, 32'h00CCBBAA, 32'h00CCBBAA},
        {3'd2, 8'h08, 32'h00002211, 32'h00002211},
        {3'd1, 8'h03, 32'h000000FF, 32'h000000FF}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           flit_valid = 1'b0;
    logic [1:0]     flit_kind = 2'b00;
    logic [1:0]     flit_vcid = 2'b00;
    logic [PW-1:0]  flit_payload = '0;
    logic           pkt_valid;
    logic [PKW-1:0] pkt_data;
    logic           pkt_consumed = 1'b0;
    logic           almost_full;
    logic           proto_err;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flit_reassembler i_flit_reassembler (
        .clk          (clk),
        .rst_n        (rst_n),
        .flit_valid   (flit_valid),
        .flit_kind    (flit_kind),
        .flit_vcid    (flit_vcid),
        .flit_payload (flit_payload),
        .pkt_valid    (pkt_valid),
        .pkt_data     (pkt_data),
        .pkt_consumed (pkt_consumed),
        .almost_full  (almost_full),
        .proto_err    (proto_err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [1:0] k, input logic [PW-1:0] p, input logic [1:0] vc);
        flit_valid = 1'b1; flit_kind = k; flit_payload = p; flit_vcid = vc;
        @(negedge clk);
        flit_valid = 1'b0; flit_kind = K_TAIL; flit_payload = 8'hE5;
    endtask

    task automatic take(input string tag, input logic [PKW-1:0] exp);
        check({tag, " valid"}, 64'(pkt_valid), 64'd1);
        check({tag, " data"}, 64'(pkt_data), 64'(exp));
        pkt_consumed = 1'b1;
        @(negedge clk);
        pkt_consumed = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        check("R1 pkt_valid", 64'(pkt_valid), 0);
        check("R1 almost_full", 64'(almost_full), 0);
        check("R1 proto_err", 64'(proto_err), 0);

        // R2 R3 R4 R5: table walk, idle cycles with junk between flits
        for (int v = 0; v < 5; v++) begin
            for (int j = 0; j < int'(VEC[v][74:72]); j++) begin
                send(VEC[v][64 + 2*j +: 2], VEC[v][32 + 8*j +: 8], 2'(v + j));
                @(negedge clk);
            end
            take($sformatf("R3 vector %0d", v), VEC[v][31:0]);
            check("R6 empty after consume", 64'(pkt_valid), 0);
        end
        check("R2 no error on clean traffic", 64'(proto_err), 0);

        // R6: consume on empty is ignored
        pkt_consumed = 1'b1;
        @(negedge clk);
        pkt_consumed = 1'b0;
        check("R6 empty consume", 64'(pkt_valid), 0);
        send(K_SOLO, 8'h33, 2'd1);
        take("R6 after empty consume", 32'h33);
        check("R6 drained", 64'(pkt_valid), 0);

        // R7: back-to-back single-flit packets, sender stops one cycle late
        begin
            bit seen = 0, lag = 0;
            int sent = 0;
            while (!lag) begin
                flit_valid = 1'b1; flit_kind = K_SOLO; flit_payload = 8'(8'h40 + sent);
                @(negedge clk);
                sent++;
                if (sent == 5) check("R7 below level", 64'(almost_full), 0);
                if (sent == 6) check("R7 at level", 64'(almost_full), 1);
                lag = seen;
                seen = almost_full;
            end
            flit_valid = 1'b0;
            check("R7 packets sent", 64'(sent), 7);
            for (int i = 0; i < sent; i++) begin
                take("R7 no loss", 32'(8'h40 + i));
                if (i == 1) check("R7 level released", 64'(almost_full), 0);
            end
            check("R7 drained", 64'(pkt_valid), 0);
        end

        // R10: fill to full, drop at full, then complete and consume together
        for (int i = 0; i < 8; i++) send(K_SOLO, 8'(8'h80 + i), 2'd0);
        check("R10 full level", 64'(almost_full), 1);
        send(K_SOLO, 8'hEE, 2'd0);
        flit_valid = 1'b1; flit_kind = K_SOLO; flit_payload = 8'h77;
        pkt_consumed = 1'b1;
        @(negedge clk);
        flit_valid = 1'b0; pkt_consumed = 1'b0;
        for (int i = 1; i < 8; i++) take("R10 order kept", 32'(8'h80 + i));
        take("R10 simultaneous store", 32'h77);
        check("R10 drop left nothing", 64'(pkt_valid), 0);

        // R8: head mid-packet restarts assembly
        send(K_HEAD, 8'h01, 2'd0);
        send(K_BODY, 8'h02, 2'd0);
        check("R8 no error yet", 64'(proto_err), 0);
        send(K_HEAD, 8'h03, 2'd0);
        send(K_TAIL, 8'h04, 2'd0);
        check("R8 restart packet", 64'(pkt_data), 64'h0403);
        check("R8 error set", 64'(proto_err), 1);
        @(negedge clk);
        check("R8 error sticky", 64'(proto_err), 1);

        // R1: reset mid-run empties the queue and clears the flag
        do_reset();
        check("R1 queue emptied", 64'(pkt_valid), 0);
        check("R1 error cleared", 64'(proto_err), 0);

        // R9: too many flits
        send(K_HEAD, 8'h01, 2'd2);
        send(K_BODY, 8'h02, 2'd2);
        send(K_BODY, 8'h03, 2'd2);
        send(K_BODY, 8'h04, 2'd2);
        check("R9 exact fit no error", 64'(proto_err), 0);
        send(K_BODY, 8'h05, 2'd2);
        send(K_TAIL, 8'h06, 2'd2);
        check("R9 overrun error", 64'(proto_err), 1);
        take("R9 overrun payload dropped", 32'h04030201);

        // R8: single-flit flit mid-packet
        do_reset();
        send(K_HEAD, 8'h09, 2'd3);
        send(K_SOLO, 8'h0A, 2'd3);
        check("R8 single mid-packet error", 64'(proto_err), 1);
        take("R8 single mid-packet data", 32'h0A);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule